// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer data-processing unit of a 32-bit RISC execute stage. Each cycle that `op_valid` is high it takes a 4-bit operation code and a first operand. It also takes a second operand, which is either a register value or a small immediate that has been rotated right by an even amount. From these it computes a result and a destination write enable, and it updates the negative, zero, carry and overflow flags. The current carry flag, the shifter's carry output and the current overflow flag come in as inputs, so the carry-chained operations and the logical operations can use or keep them.

Sixteen operations share one map. Six are bitwise. Eight use the adder: plain, reversed-operand and carry-chained add and subtract, plus the two compares. Two are tests. The two tests and the two compares update the flags but never request a register write. Subtraction reports carry as an inverted borrow. The outputs are registered, so results appear one clock after the operation is presented.

Top module: `dp_alu`

## Requirements
- R1: While reset is asserted, and after it is released until the first operation, `res_valid`, `result`, `wr_en` and all four flags are 0.
- R2: Bitwise codes: 0 gives first AND second, 1 gives XOR, 12 gives OR, 13 passes the second operand, 14 gives first AND NOT second, and 15 gives NOT second.
- R3: Code 4 adds the operands. Code 2 subtracts the second operand from the first. Code 3 subtracts the first operand from the second. Each result wraps modulo 2^32.
- R4: Code 5 adds the operands plus `carry_in`. Code 6 computes first minus second minus (1 - `carry_in`). Code 7 computes second minus first minus (1 - `carry_in`).
- R5: Codes 8, 9, 10 and 11 set the flags from AND, XOR, subtract and add respectively, and drive `wr_en` to 0. Every other code drives `wr_en` to 1.
- R6: When `use_imm` is 1, the second operand is `imm8` zero-extended to 32 bits and rotated right by 2 × `rot4` bit positions. When `use_imm` is 0, the second operand is `rm_val`.
- R7: `flag_n` equals result bit 31, and `flag_z` is 1 exactly when the result is zero. This holds for every code, including codes that do not write.
- R8: For the adder codes, `flag_c` is the unsigned carry out of the addition. For the subtract forms it is therefore 1 when no borrow occurs. `flag_v` is 1 when the signed result does not fit in 32 bits.
- R9: For the bitwise and test codes (0, 1, 8, 9, 12 to 15), `flag_c` equals `shift_carry` and `flag_v` equals `v_in`.
- R10: Outputs reflect the operation presented one clock earlier, and `res_valid` is `op_valid` delayed by one clock. In a cycle with `op_valid` low, the result, write enable and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation code |
| rn_val | input | 32 | First operand |
| rm_val | input | 32 | Register form of the second operand |
| use_imm | input | 1 | Select the rotated immediate as the second operand |
| imm8 | input | 8 | Immediate value |
| rot4 | input | 4 | Rotate amount in units of two bits |
| carry_in | input | 1 | Current carry flag |
| shift_carry | input | 1 | Shifter carry output, used by the bitwise codes |
| v_in | input | 1 | Current overflow flag |
| res_valid | output | 1 | Registered outputs hold a new operation |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write request |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Directed operands probe the adder boundaries. All-ones plus one separates carry from overflow. The largest positive value plus one gives overflow without carry. Equal operands in a subtract produce zero together with a set carry. Zero minus one and the most negative value minus one separate the borrow from signed overflow. Carry-chained and reversed subtracts are run with the incoming carry both 0 and 1, which exposes a reversed operand order or an inverted carry. Immediates at several rotate amounts, including ones that wrap bits across bit 31, check the rotator. A long random run over all codes, both operand sources and random flag inputs compares every output with a reference model, and idle cycles confirm that the outputs hold.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND   = 4'h0,
      OP_XOR   = 4'h1,
      OP_SUB   = 4'h2,
      OP_RSUB  = 4'h3,
      OP_ADD   = 4'h4,
      OP_ADDC  = 4'h5,
      OP_SUBC  = 4'h6,
      OP_RSUBC = 4'h7,
      OP_TEST  = 4'h8,
      OP_TXOR  = 4'h9,
      OP_CMP   = 4'hA,
      OP_CMPA  = 4'hB,
      OP_OR    = 4'hC,
      OP_MOVE  = 4'hD,
      OP_ANDN  = 4'hE,
      OP_NOT   = 4'hF
   } alu_op_e;

   typedef enum logic [1:0] {
      CIN_ZERO = 2'd0,
      CIN_ONE  = 2'd1,
      CIN_FLAG = 2'd2
   } cin_sel_e;

   typedef struct packed {
      logic     arith;   // adder path drives result and C/V
      logic     swap;    // second operand feeds the adder's A input
      logic     inv_b;   // adder B input is complemented
      cin_sel_e cin_sel;
      logic     writes;  // destination write requested
   } alu_ctl_t;

   function automatic alu_ctl_t decode_op(alu_op_e op);
      alu_ctl_t c;
      c = '{arith: 1'b0, swap: 1'b0, inv_b: 1'b0, cin_sel: CIN_ZERO, writes: 1'b1};
      case (op)
         OP_SUB:   begin c.arith = 1'b1; c.inv_b = 1'b1; c.cin_sel = CIN_ONE; end
         OP_RSUB:  begin c.arith = 1'b1; c.swap = 1'b1; c.inv_b = 1'b1; c.cin_sel = CIN_ONE; end
         OP_ADD:   begin c.arith = 1'b1; end
         OP_ADDC:  begin c.arith = 1'b1; c.cin_sel = CIN_FLAG; end
         OP_SUBC:  begin c.arith = 1'b1; c.inv_b = 1'b1; c.cin_sel = CIN_FLAG; end
         OP_RSUBC: begin c.arith = 1'b1; c.swap = 1'b1; c.inv_b = 1'b1; c.cin_sel = CIN_FLAG; end
         OP_TEST,
         OP_TXOR:  begin c.writes = 1'b0; end
         OP_CMP:   begin c.arith = 1'b1; c.inv_b = 1'b1; c.cin_sel = CIN_ONE; c.writes = 1'b0; end
         OP_CMPA:  begin c.arith = 1'b1; c.writes = 1'b0; end
         default:  ;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/dp_alu_operand.sv
module dp_alu_operand #(
   parameter int DW    = 32,
   parameter int IMM_W = 8,
   parameter int ROT_W = 4
) (
   input  logic [DW-1:0]    rm_val,
   input  logic             use_imm,
   input  logic [IMM_W-1:0] imm8,
   input  logic [ROT_W-1:0] rot4,
   output logic [DW-1:0]    op2
);
   localparam int NROT    = 2 ** ROT_W;
   localparam int MAX_SHF = 2 * (NROT - 1);

   generate
      if (IMM_W > DW) begin : g_bad_imm
         $error("dp_alu_operand: IMM_W must not exceed DW");
      end
      if (MAX_SHF >= DW) begin : g_bad_rot
         $error("dp_alu_operand: largest rotate must be below DW");
      end
   endgenerate

   logic [DW-1:0]   imm_ext;
   logic [DW-1:0]   rot_tab [NROT];

   assign imm_ext = {{(DW-IMM_W){1'b0}}, imm8};

   // One fixed rotation per rotate code; the code selects among them.
   generate
      for (genvar k = 0; k < NROT; k++) begin : g_rot
         logic [2*DW-1:0] dbl;
         assign dbl        = {imm_ext, imm_ext} >> (2 * k);
         assign rot_tab[k] = dbl[DW-1:0];
      end
   endgenerate

   assign op2 = use_imm ? rot_tab[rot4] : rm_val;

endmodule

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          cin,
   output logic [DW-1:0] sum,
   output logic          cout,
   output logic          ovf
);
   localparam int MSB = DW - 1;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("dp_alu_addsub: DW must be at least 2");
      end
   endgenerate

   logic [DW:0] wide;

   assign wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
   assign sum  = wide[DW-1:0];
   assign cout = wide[DW];
   // Overflow: like-signed inputs yielding a differently signed sum.
   assign ovf  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic #(
   parameter int DW = 32
) (
   input  dp_alu_pkg::alu_op_e op,
   input  logic [DW-1:0]       a,
   input  logic [DW-1:0]       b,
   output logic [DW-1:0]       y
);
   import dp_alu_pkg::*;

   always_comb begin
      case (op)
         OP_AND, OP_TEST: y = a & b;
         OP_XOR, OP_TXOR: y = a ^ b;
         OP_OR:           y = a | b;
         OP_MOVE:         y = b;
         OP_ANDN:         y = a & ~b;
         OP_NOT:          y = ~b;
         default:         y = '0;
      endcase
   end

endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
   parameter int DW    = 32,
   parameter int IMM_W = 8,
   parameter int ROT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [3:0]       opcode,
   input  logic [DW-1:0]    rn_val,
   input  logic [DW-1:0]    rm_val,
   input  logic             use_imm,
   input  logic [IMM_W-1:0] imm8,
   input  logic [ROT_W-1:0] rot4,
   input  logic             carry_in,
   input  logic             shift_carry,
   input  logic             v_in,
   output logic             res_valid,
   output logic [DW-1:0]    result,
   output logic             wr_en,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_c,
   output logic             flag_v
);
   import dp_alu_pkg::*;

   localparam int MSB = DW - 1;

   alu_op_e       op;
   alu_ctl_t      ctl;
   logic [DW-1:0] op2;
   logic [DW-1:0] add_a, add_b, b_src;
   logic          add_cin;
   logic [DW-1:0] sum, lres, nxt_res;
   logic          cout, ovf, nxt_c, nxt_v;

   assign op  = alu_op_e'(opcode);
   assign ctl = decode_op(op);

   dp_alu_operand #(.DW(DW), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_operand (
      .rm_val (rm_val),
      .use_imm(use_imm),
      .imm8   (imm8),
      .rot4   (rot4),
      .op2    (op2)
   );

   // Adder inputs: optional swap for the reversed forms, optional
   // complement for subtraction, carry-in from the decoded selector.
   assign add_a = ctl.swap ? op2 : rn_val;
   assign b_src = ctl.swap ? rn_val : op2;
   assign add_b = ctl.inv_b ? ~b_src : b_src;

   always_comb begin
      case (ctl.cin_sel)
         CIN_ONE:  add_cin = 1'b1;
         CIN_FLAG: add_cin = carry_in;
         default:  add_cin = 1'b0;
      endcase
   end

   dp_alu_addsub #(.DW(DW)) u_addsub (
      .a   (add_a),
      .b   (add_b),
      .cin (add_cin),
      .sum (sum),
      .cout(cout),
      .ovf (ovf)
   );

   dp_alu_logic #(.DW(DW)) u_logic (
      .op(op),
      .a (rn_val),
      .b (op2),
      .y (lres)
   );

   assign nxt_res = ctl.arith ? sum  : lres;
   assign nxt_c   = ctl.arith ? cout : shift_carry;
   assign nxt_v   = ctl.arith ? ovf  : v_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         result    <= '0;
         wr_en     <= 1'b0;
         flag_n    <= 1'b0;
         flag_z    <= 1'b0;
         flag_c    <= 1'b0;
         flag_v    <= 1'b0;
      end else begin
         res_valid <= op_valid;
         if (op_valid) begin
            result <= nxt_res;
            wr_en  <= ctl.writes;
            flag_n <= nxt_res[MSB];
            flag_z <= (nxt_res == '0);
            flag_c <= nxt_c;
            flag_v <= nxt_v;
         end
      end
   end

   // R10: one-cycle latency of the valid strobe
   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);
   // R10: idle cycle leaves every output unchanged
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!res_valid && $stable(result) && $stable(wr_en) &&
                     $stable(flag_c) && $stable(flag_v)));
   // R5: tests and compares never request a write
   a_r5_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opcode[3:2] == 2'b10) |=> !wr_en);
   // R5: every other code writes
   a_r5_write: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opcode[3:2] != 2'b10) |=> wr_en);
   // R9: bitwise codes carry the incoming shifter carry and overflow
   a_r9_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !ctl.arith) |=> (flag_c == $past(shift_carry) && flag_v == $past(v_in)));
   // R7: N and Z agree with the registered result
   a_r7_nz_match: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (flag_n == result[MSB] && flag_z == (result == '0)));
   // R6: register-form move returns the register operand
   a_r6_reg_move: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opcode == 4'hD && !use_imm) |=> result == $past(rm_val));

endmodule

// File: tb/dp_alu_bench.sv
`timescale 1ns/1ps
module dp_alu_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  opcode = '0;
   logic [31:0] rn_val = '0, rm_val = '0;
   logic        use_imm = 1'b0;
   logic [7:0]  imm8 = '0;
   logic [3:0]  rot4 = '0;
   logic        carry_in = 1'b0, shift_carry = 1'b0, v_in = 1'b0;
   logic        res_valid, wr_en, flag_n, flag_z, flag_c, flag_v;
   logic [31:0] result;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   dp_alu u_dp_alu (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
      .rn_val(rn_val), .rm_val(rm_val), .use_imm(use_imm), .imm8(imm8),
      .rot4(rot4), .carry_in(carry_in), .shift_carry(shift_carry), .v_in(v_in),
      .res_valid(res_valid), .result(result), .wr_en(wr_en), .flag_n(flag_n),
      .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
   );

   // R6 model: zero-extend then rotate right by twice the code
   function automatic logic [31:0] imm_val(logic [7:0] i, logic [3:0] r);
      logic [31:0] x = {24'd0, i};
      int s = 2 * int'(r);
      if (s == 0) return x;
      return (x >> s) | (x << (32 - s));
   endfunction

   // Expected {wr, n, z, c, v, result}
   function automatic logic [36:0] model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                         logic c, logic sc, logic v);
      logic [31:0] r;
      logic cc, vv, wr;
      longint sa, sb, s;
      longint unsigned ua, ub, nb;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      ua = {32'd0, a};
      ub = {32'd0, b};
      nb = c ? 64'd0 : 64'd1;
      wr = !(op >= 4'h8 && op <= 4'hB);
      cc = sc; vv = v; s = 0; r = '0;
      case (op)
         4'h0, 4'h8: r = a & b;
         4'h1, 4'h9: r = a ^ b;
         4'hC: r = a | b;
         4'hD: r = b;
         4'hE: r = a & ~b;
         4'hF: r = ~b;
         4'h4, 4'hB: begin s = sa + sb; r = a + b; cc = (ua + ub) > 64'hFFFF_FFFF; end
         4'h5: begin s = sa + sb + (c ? 1 : 0); r = a + b + {31'd0, c};
                     cc = (ua + ub + (c ? 64'd1 : 64'd0)) > 64'hFFFF_FFFF; end
         4'h2, 4'hA: begin s = sa - sb; r = a - b; cc = ua >= ub; end
         4'h3: begin s = sb - sa; r = b - a; cc = ub >= ua; end
         4'h6: begin s = sa - sb - longint'(nb); r = a - b - nb[31:0]; cc = ua >= ub + nb; end
         4'h7: begin s = sb - sa - longint'(nb); r = b - a - nb[31:0]; cc = ub >= ua + nb; end
         default: ;
      endcase
      if ((op >= 4'h2 && op <= 4'h7) || op == 4'hA || op == 4'hB)
         vv = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      return {wr, r[31], (r == 32'd0), cc, vv, r};
   endfunction

   function automatic string req_of(logic [3:0] op);
      if (op >= 4'h8 && op <= 4'hB) return "R5";
      if (op == 4'h5 || op == 4'h6 || op == 4'h7) return "R4";
      if (op >= 4'h2 && op <= 4'h4) return "R3/R8";
      return "R2/R9";
   endfunction

   task automatic run_op(logic [3:0] op, logic [31:0] a, logic [31:0] m, logic ui,
                         logic [7:0] i, logic [3:0] r, logic c, logic sc, logic v,
                         string tag);
      logic [36:0] exp, act;
      logic [31:0] b;
      @(negedge clk);
      op_valid = 1'b1; opcode = op; rn_val = a; rm_val = m; use_imm = ui;
      imm8 = i; rot4 = r; carry_in = c; shift_carry = sc; v_in = v;
      b = ui ? imm_val(i, r) : m;
      exp = model(op, a, b, c, sc, v);
      @(negedge clk);
      op_valid = 1'b0;
      act = {wr_en, flag_n, flag_z, flag_c, flag_v, result};
      checks++;
      if (act !== exp || res_valid !== 1'b1) begin
         failures++;
         $display("FAIL %s op=%h actual=%h valid=%b expected=%h", tag, op, act, res_valid, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [36:0] held;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1: reset state while asserted and just after release
      checks++;
      if ({res_valid, result, wr_en, flag_n, flag_z, flag_c, flag_v} !== '0) begin
         failures++;
         $display("FAIL R1 actual=%h expected=0", {res_valid, result, wr_en, flag_n, flag_z, flag_c, flag_v});
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if ({res_valid, result, wr_en, flag_n, flag_z, flag_c, flag_v} !== '0) begin
         failures++;
         $display("FAIL R1 after release actual=%h expected=0", {res_valid, result, wr_en, flag_n, flag_z, flag_c, flag_v});
      end

      // R8 adder boundaries
      run_op(4'h4, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, 0, 0, "R8 carry no overflow");
      run_op(4'h4, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, 0, 0, 0, "R8 overflow no carry");
      run_op(4'h2, 32'd5, 32'd5, 0, 0, 0, 0, 0, 0, "R8 equal subtract zero carry");
      run_op(4'h2, 32'd0, 32'd1, 0, 0, 0, 0, 1, 1, "R8 borrow");
      run_op(4'h2, 32'h8000_0000, 32'd1, 0, 0, 0, 0, 0, 0, "R8 signed overflow sub");
      run_op(4'h3, 32'd3, 32'd10, 0, 0, 0, 0, 0, 0, "R3 reverse subtract");
      // R4 with carry 0 and 1
      run_op(4'h5, 32'd7, 32'd8, 0, 0, 0, 1, 0, 0, "R4 add carry 1");
      run_op(4'h6, 32'd5, 32'd3, 0, 0, 0, 0, 0, 0, "R4 sub carry 0");
      run_op(4'h6, 32'd5, 32'd3, 0, 0, 0, 1, 0, 0, "R4 sub carry 1");
      run_op(4'h7, 32'd3, 32'd10, 0, 0, 0, 0, 0, 0, "R4 rsub carry 0");
      run_op(4'h7, 32'd3, 32'd3, 0, 0, 0, 1, 0, 0, "R4 rsub carry 1");
      // R6 immediate rotation, including wrap across bit 31
      run_op(4'hD, 32'd0, 32'hDEAD_BEEF, 1, 8'hFF, 4'd4, 0, 0, 0, "R6 imm rot 8");
      run_op(4'hD, 32'd0, 32'hDEAD_BEEF, 1, 8'h03, 4'd1, 0, 0, 0, "R6 imm wrap");
      run_op(4'hD, 32'd0, 32'hDEAD_BEEF, 1, 8'hA5, 4'd15, 0, 0, 0, "R6 imm rot 30");
      run_op(4'hD, 32'd0, 32'h1234_5678, 0, 8'hFF, 4'd4, 0, 0, 0, "R6 register form");
      // R5 and R7 tests and compares
      run_op(4'h9, 32'h55AA_55AA, 32'h55AA_55AA, 0, 0, 0, 0, 1, 0, "R5 R7 equal xor test");
      run_op(4'hA, 32'd1, 32'd2, 0, 0, 0, 0, 0, 0, "R5 R7 compare negative");
      run_op(4'hF, 32'd0, 32'd0, 0, 0, 0, 0, 1, 1, "R2 R9 not of zero");

      // R10: idle cycle holds outputs
      held = {wr_en, flag_n, flag_z, flag_c, flag_v, result};
      opcode = 4'h4; rn_val = 32'h1111_1111; rm_val = 32'h2222_2222; carry_in = 1;
      @(negedge clk);
      checks++;
      if ({wr_en, flag_n, flag_z, flag_c, flag_v, result} !== held || res_valid !== 1'b0) begin
         failures++;
         $display("FAIL R10 hold actual=%h valid=%b expected=%h valid=0",
                  {wr_en, flag_n, flag_z, flag_c, flag_v, result}, res_valid, held);
      end

      // Random mix over every code and both operand sources
      for (int n = 0; n < 4000; n++) begin
         logic [3:0] op = 4'($urandom);
         logic [31:0] a = $urandom;
         logic [31:0] m = $urandom;
         if ($urandom % 4 == 0) a = ($urandom % 2) ? 32'h8000_0000 : 32'hFFFF_FFFF;
         if ($urandom % 8 == 0) m = a;
         run_op(op, a, m, 1'($urandom), 8'($urandom), 4'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), req_of(op));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule